// File: doc/BRIEF.md
# RTC Shadow Register Update Controller

This block separates a byte-wide host register port from the live time counters of a real-time clock. The host never writes the running counters directly. It fills a time buffer and an alarm buffer byte by byte, then writes request bits into an update register. After a transfer delay, counted in ticks of a slow reference clock, the block commits the request. It loads the buffered time into the counter core, latches the running time into a snapshot that the host can read back, or hands the buffered alarm to the compare logic. The host learns that a transfer has finished by polling the request bits. Each bit reads 1 while its transfer is pending.

Two delays are available, a long one and a short one, chosen per request. Three options are set by parameter. The time block is 7 or 8 bytes long, and the 8th byte holds the upper part of the year. A write-time request can be made to need a time-enable bit set in the same write. The alarm request bit can be made to stay set after its transfer until the host clears it.

Top module: `rtc_shadow_ctl`

## Requirements
- R1: After reset the update register (address 0x21) and the control register (address 0x20) read 0, and `load_time`, `alarm_val`, `load_stb` and `alarm_stb` are 0.
- R2: Writes to the time buffer at addresses 0x00 to 0x00+NB-1 never change `load_time` until a write-time transfer completes.
- R3: Writing the update register with bit 0 set starts a write-time transfer. Bit 0 reads 1 until the transfer completes. At completion `load_time` takes the buffered time (byte i at address i in bits 8i+7..8i), `load_stb` pulses for one cycle and bit 0 clears.
- R4: Bit 4 of the update register selects the delay: 1 gives FAST_TICKS reference ticks and 0 gives SLOW_TICKS. The delay counts only cycles with `tick` high. With `tick` held high, bit 0 reads back clear on the read issued delay+1 cycles after the write cycle.
- R5: Bit 1 of the update register requests a read update. At completion the snapshot takes `live_time`, and reads of addresses 0x00 to 0x00+NB-1 return snapshot bytes. Later changes of `live_time` are not visible until the next read update.
- R6: Bit 2 of the update register commits the alarm buffer at addresses 0x10 to 0x10+NB-1 to `alarm_val` and pulses `alarm_stb`. Buffer writes alone leave `alarm_val` unchanged. With ALARM_STICKY=0, bit 2 clears at completion.
- R7: With ALARM_STICKY=1, bit 2 still reads 1 after its transfer completes. A later idle write of the update register with bit 2 at 0 clears it.
- R8: With NEED_TIME_EN=1, a write-time request is accepted only if bit 3 (time-enable) is 1 in the same write. A write that requests an alarm commit leaves bit 3 at 0.
- R9: A write to the update register while a transfer is in progress is ignored completely: no request, enable or delay bit changes, and no extra transfer follows.
- R10: The control register at address 0x20 holds BCD mode in bit 0 and 24-hour mode in bit 1. It drives `bcd_mode` and `hr24_mode` and reads back.
- R11: With NB=7 there is no year-high byte: address 0x07 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference clock enable, one pulse per delay tick |
| bus_addr | input | 8 | Register address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| live_time | input | NB*8 | Running time from the counter core |
| load_stb | output | 1 | One-cycle pulse when load_time is updated |
| load_time | output | NB*8 | Time value committed to the counter core |
| alarm_stb | output | 1 | One-cycle pulse when alarm_val is updated |
| alarm_val | output | NB*8 | Committed alarm value |
| bcd_mode | output | 1 | BCD mode from the control register |
| hr24_mode | output | 1 | 24-hour mode from the control register |

## Verification
The hardest case to reach is a host write that arrives in the middle of a transfer. It must leave no trace: no request bits, and no change to the enable or delay bits. The bench starts a long-delay time write and issues a read-update request a few cycles later. It then reads the update register back while the transfer is still running, and finally confirms that the snapshot never moved even though `live_time` had changed. A second hard case is a transfer that stalls when `tick` stops. To reach it, the bench holds `tick` low for several times the short delay and checks that the request bit is still pending.

// File: rtl/rtc_shd_pkg.sv
package rtc_shd_pkg;
  // register addresses
  localparam logic [7:0] A_TIME = 8'h00;
  localparam logic [7:0] A_ALRM = 8'h10;
  localparam logic [7:0] A_CTRL = 8'h20;
  localparam logic [7:0] A_UPD  = 8'h21;
  // update register bit positions
  localparam int B_WT   = 0;
  localparam int B_RD   = 1;
  localparam int B_AL   = 2;
  localparam int B_TE   = 3;
  localparam int B_FAST = 4;
  // control register bit positions
  localparam int C_BCD = 0;
  localparam int C_H24 = 1;
endpackage

// File: rtl/rtc_shd_bytebank.sv
module rtc_shd_bytebank
  import rtc_shd_pkg::*;
#(
  parameter int         NB   = 7,
  parameter logic [7:0] BASE = 8'h00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [7:0]      addr,
  input  logic [7:0]      wdata,
  output logic [NB*8-1:0] q
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) q[g*8 +: 8] <= '0;
      else if (wr && addr == BASE + 8'(g)) q[g*8 +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/rtc_shd_xfer.sv
module rtc_shd_xfer #(
  parameter int SLOW_TICKS = 240,
  parameter int FAST_TICKS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  input  logic fast,
  output logic busy,
  output logic fin
);
  localparam int MAXT = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt, lim_q;

  assign fin = busy && tick && (cnt == lim_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      lim_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt   <= '0;
      lim_q <= fast ? CW'(FAST_TICKS) : CW'(SLOW_TICKS);
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rtc_shd_rdmux.sv
module rtc_shd_rdmux
  import rtc_shd_pkg::*;
#(
  parameter int NB = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      addr,
  input  logic [NB*8-1:0] snap,
  input  logic [NB*8-1:0] alm,
  input  logic [7:0]      ctrl_byte,
  input  logic [7:0]      upd_byte,
  output logic [7:0]      rdata
);
  logic [7:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr == A_TIME + 8'(i)) sel = snap[i*8 +: 8];
      if (addr == A_ALRM + 8'(i)) sel = alm[i*8 +: 8];
    end
    if (addr == A_CTRL) sel = ctrl_byte;
    if (addr == A_UPD)  sel = upd_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/rtc_shadow_ctl.sv
module rtc_shadow_ctl
  import rtc_shd_pkg::*;
#(
  parameter int NB           = 7,
  parameter int SLOW_TICKS   = 240,
  parameter int FAST_TICKS   = 15,
  parameter bit ALARM_STICKY = 1'b0,
  parameter bit NEED_TIME_EN = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [7:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic            bus_wr,
  output logic [7:0]      bus_rdata,
  input  logic [NB*8-1:0] live_time,
  output logic            load_stb,
  output logic [NB*8-1:0] load_time,
  output logic            alarm_stb,
  output logic [NB*8-1:0] alarm_val,
  output logic            bcd_mode,
  output logic            hr24_mode
);
  localparam int W = NB * 8;

  logic [W-1:0] time_buf, alm_buf, snap;
  logic         busy, fin;
  logic         fly_wt, fly_rd, fly_al, al_hold, te_q, fast_q;
  logic [1:0]   ctrl_q;
  logic         upd_wr, ctrl_wr, accept, want_wt, start;
  logic [7:0]   upd_byte;
  logic [2:0]   unused_wbits;

  assign unused_wbits = bus_wdata[7:5];

  rtc_shd_bytebank #(.NB(NB), .BASE(A_TIME)) u_tbuf (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .q(time_buf));

  rtc_shd_bytebank #(.NB(NB), .BASE(A_ALRM)) u_abuf (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .q(alm_buf));

  assign upd_wr  = bus_wr && (bus_addr == A_UPD);
  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign accept  = upd_wr && !busy;
  assign want_wt = bus_wdata[B_WT] && (!NEED_TIME_EN || bus_wdata[B_TE]);
  assign start   = accept && (want_wt || bus_wdata[B_RD] || bus_wdata[B_AL]);

  rtc_shd_xfer #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) u_xfer (
    .clk(clk), .rst(rst), .tick(tick), .start(start),
    .fast(bus_wdata[B_FAST]), .busy(busy), .fin(fin));

  always_ff @(posedge clk) begin
    if (rst) begin
      fly_wt    <= 1'b0;
      fly_rd    <= 1'b0;
      fly_al    <= 1'b0;
      al_hold   <= 1'b0;
      te_q      <= 1'b0;
      fast_q    <= 1'b0;
      load_stb  <= 1'b0;
      alarm_stb <= 1'b0;
      load_time <= '0;
      alarm_val <= '0;
      snap      <= '0;
    end else begin
      load_stb  <= 1'b0;
      alarm_stb <= 1'b0;
      if (accept) begin
        fast_q  <= bus_wdata[B_FAST];
        te_q    <= bus_wdata[B_TE] & ~bus_wdata[B_AL];
        fly_wt  <= want_wt;
        fly_rd  <= bus_wdata[B_RD];
        fly_al  <= bus_wdata[B_AL];
        al_hold <= 1'b0;
      end else if (fin) begin
        fly_wt <= 1'b0;
        fly_rd <= 1'b0;
        fly_al <= 1'b0;
        if (fly_wt) begin
          load_time <= time_buf;
          load_stb  <= 1'b1;
        end
        if (fly_rd) snap <= live_time;
        if (fly_al) begin
          alarm_val <= alm_buf;
          alarm_stb <= 1'b1;
          al_hold   <= ALARM_STICKY;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[1:0];
  end

  assign bcd_mode  = ctrl_q[C_BCD];
  assign hr24_mode = ctrl_q[C_H24];
  assign upd_byte  = {3'b000, fast_q, te_q, fly_al | al_hold, fly_rd, fly_wt};

  rtc_shd_rdmux #(.NB(NB)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .snap(snap), .alm(alarm_buf_rd()),
    .ctrl_byte({6'b0, ctrl_q}), .upd_byte(upd_byte), .rdata(bus_rdata));

  function automatic logic [W-1:0] alarm_buf_rd();
    return alm_buf;
  endfunction
endmodule

// File: rtl/rtc_shadow_ctl_chk.sv
module rtc_shadow_ctl_chk #(
  parameter int W = 56
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         fly_wt,
  input logic         fly_rd,
  input logic         fly_al,
  input logic         load_stb,
  input logic [W-1:0] load_time,
  input logic         alarm_stb,
  input logic [W-1:0] alarm_val
);
  AST_LOAD_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(load_time) |-> load_stb); // R2
  AST_LOAD_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb); // R3
  AST_WT_CLEAR_LOADS: assert property (@(posedge clk) disable iff (rst)
    $fell(fly_wt) |-> load_stb); // R3
  AST_ALARM_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(alarm_val) |-> alarm_stb); // R6
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable({fly_wt, fly_rd, fly_al})); // R9
  AST_PENDING_BUSY: assert property (@(posedge clk) disable iff (rst)
    (fly_wt || fly_rd || fly_al) |-> busy); // R4
endmodule

bind rtc_shadow_ctl rtc_shadow_ctl_chk #(.W(NB*8)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .fly_wt(fly_wt), .fly_rd(fly_rd),
  .fly_al(fly_al), .load_stb(load_stb), .load_time(load_time),
  .alarm_stb(alarm_stb), .alarm_val(alarm_val));

// File: tb/sim_rtc_shadow_ctl.sv
module sim_rtc_shadow_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 20;
  localparam int FAST = 5;
  localparam logic [7:0] A_ALRM = 8'h10, A_CTRL = 8'h20, A_UPD = 8'h21;

  logic        clk = 1'b0, rst = 1'b1, tick = 1'b1, wr = 1'b0;
  logic [7:0]  addr = 8'h00, wdata = 8'h00, rd0, rd1;
  logic [63:0] live = 64'h0;
  logic        ls0, ls1, as0, as1, bcd0, bcd1, h0, h1;
  logic [55:0] lt0, av0;
  logic [63:0] lt1, av1;
  int nchk = 0, nfail = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_shadow_ctl #(.NB(7), .SLOW_TICKS(SLOW), .FAST_TICKS(FAST)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr), .bus_rdata(rd0), .live_time(live[55:0]), .load_stb(ls0),
    .load_time(lt0), .alarm_stb(as0), .alarm_val(av0), .bcd_mode(bcd0),
    .hr24_mode(h0));

  rtc_shadow_ctl #(.NB(8), .SLOW_TICKS(SLOW), .FAST_TICKS(FAST),
                   .ALARM_STICKY(1'b1), .NEED_TIME_EN(1'b1)) u1 (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr), .bus_rdata(rd1), .live_time(live), .load_stb(ls1),
    .load_time(lt1), .alarm_stb(as1), .alarm_val(av1), .bcd_mode(bcd1),
    .hr24_mode(h1));

  // {te, fast, time pattern}
  localparam logic [65:0] VEC [4] = '{
    {1'b1, 1'b1, 64'h2024_0615_1013_4530},
    {1'b0, 1'b1, 64'h1999_1231_4023_5959},
    {1'b1, 1'b0, 64'h2000_0101_0100_0000},
    {1'b1, 1'b1, 64'hA55A_C33C_0FF0_817E}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    addr = a;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_time(input logic [63:0] p);
    for (int i = 0; i < 8; i++) bus_write(8'(i), p[i*8 +: 8]);
  endtask

  // returns cycles until bit idx of u0 update register reads 0
  task automatic poll(input int idx, output int n, output logic [7:0] first1);
    n = 0; first1 = 8'h00; addr = A_UPD;
    do begin
      @(posedge clk); @(negedge clk); n++;
      if (n == 1) first1 = rd1;
    end while (rd0[idx] && n < 1000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!ended) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] f1;
    logic [63:0] exp1, ap, l1, p5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 load_time", {8'h0, lt0}, 64'h0);
    check("R1 alarm_val", av1, 64'h0);
    check("R1 strobes", {ls0, as0, ls1, as1}, 0);
    bus_read(A_UPD);
    check("R1 upd u0", rd0, 0);
    check("R1 upd u1", rd1, 0);
    bus_read(A_CTRL);
    check("R1 ctrl", {rd0, rd1}, 0);

    exp1 = 64'h0;
    for (int k = 0; k < 4; k++) begin
      logic te, fs;
      logic [63:0] p;
      logic [55:0] prev0;
      te = VEC[k][65]; fs = VEC[k][64]; p = VEC[k][63:0];
      prev0 = lt0;
      write_time(p);
      check("R2 buffer isolation", {8'h0, lt0}, {8'h0, prev0});
      bus_write(A_UPD, {3'b0, fs, te, 3'b001});
      poll(0, n, f1);
      check("R4 delay", n, fs ? FAST + 1 : SLOW + 1);
      check("R3 load u0", {8'h0, lt0}, {8'h0, p[55:0]});
      check("R8 te gate pending", f1[0], te);
      if (te) exp1 = p;
      check(te ? "R3 load u1" : "R8 load ignored", lt1, exp1);
    end

    // alarm commit
    ap = 64'h0021_090C_0206_1E08;
    for (int i = 0; i < 8; i++) bus_write(A_ALRM + 8'(i), ap[i*8 +: 8]);
    check("R6 alarm buffer isolation", {av0, av1[7:0]}, 64'h0);
    bus_write(A_UPD, 8'h1C);
    poll(2, n, f1);
    check("R6 alarm delay", n, FAST + 1);
    check("R6 alarm u0", {8'h0, av0}, {8'h0, ap[55:0]});
    check("R6 alarm u1", av1, ap);
    bus_read(A_UPD);
    check("R6 R8 upd u0", rd0, 8'h10);
    check("R7 R8 sticky u1", rd1, 8'h14);
    bus_write(A_UPD, 8'h10);
    bus_read(A_UPD);
    check("R7 sticky cleared", rd1, 8'h10);

    // read update
    l1 = 64'h2025_0314_0509_3015;
    live = l1;
    bus_write(A_UPD, 8'h12);
    poll(1, n, f1);
    check("R5 read delay", n, FAST + 1);
    for (int i = 0; i < 7; i++) begin
      bus_read(8'(i));
      check("R5 snapshot u0", rd0, l1[i*8 +: 8]);
      check("R5 snapshot u1", rd1, l1[i*8 +: 8]);
    end
    bus_read(8'h07);
    check("R11 no year-high u0", rd0, 0);
    check("R5 year-high u1", rd1, l1[63:56]);
    live = ~l1;
    bus_read(8'h03);
    check("R5 snapshot held", rd0, l1[31:24]);

    // write during transfer is ignored
    p5 = 64'h2031_1122_3344_5566;
    write_time(p5);
    bus_write(A_UPD, 8'h09);
    repeat (2) @(negedge clk);
    bus_write(A_UPD, 8'h12);
    bus_read(A_UPD);
    check("R9 ignored u0", rd0, 8'h09);
    check("R9 ignored u1", rd1, 8'h09);
    poll(0, n, f1);
    bus_read(A_UPD);
    check("R9 no extra transfer", {rd0, rd1}, 16'h0808);
    bus_read(8'h00);
    check("R9 snapshot untouched", rd0, l1[7:0]);
    check("R3 slow load u1", lt1, p5);

    // tick gating
    write_time(64'h2040_0102_0304_0506);
    bus_write(A_UPD, 8'h19);
    tick = 1'b0;
    repeat (3 * FAST) @(negedge clk);
    bus_read(A_UPD);
    check("R4 stalled without tick", rd0[0], 1'b1);
    check("R4 no load while stalled", {8'h0, lt0}, {8'h0, p5[55:0]});
    tick = 1'b1;
    poll(0, n, f1);
    check("R4 resumes", {8'h0, lt0}, 64'h0040_0102_0304_0506);

    // control register
    bus_write(A_CTRL, 8'h03);
    check("R10 modes", {bcd0, h0, bcd1, h1}, 4'hF);
    bus_read(A_CTRL);
    check("R10 readback", rd0, 8'h03);
    bus_write(A_CTRL, 8'h02);
    check("R10 bcd off", {bcd1, h0}, 2'b01);

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule